// File: doc/BRIEF.md
# Conditional Skip Decision Unit

This block decides whether a one-cycle skip instruction should make the program counter step past the next instruction. It looks at the 12-bit address field of the instruction and treats it as a group of independent selectors. One bit tests the sign of the in-out register. One bit tests the overflow flip-flop. A three-bit field picks one sense switch, or all of them. Another three-bit field picks one program flag, or all of them. When more than one selector is active, their conditions are combined by inclusive OR. The result is a single skip strobe. It is valid in the same cycle as the execute enable, so a combined skip costs no more time than a single one.

The block also holds the overflow flip-flop. Arithmetic logic outside the block sets it. It is cleared by the start control, and it is cleared when an instruction that tests overflow executes. Reset is asserted asynchronously and active low. Its release is synchronised inside the block.

Top module: `skip_decider`

## Requirements
- R1: With address bit 10 set (octal 2000) and execute enable high, `skip` is 1 when `io_sign` is 0.
- R2: Address bits [5:3] form the switch selector. A value n from 1 to 6 (octal address n0) gives `skip` when `sense_sw[n-1]` is 0.
- R3: A switch selector value of 7 (octal 70) gives `skip` only when all six bits of `sense_sw` are 0.
- R4: Address bits [2:0] form the flag selector. A value n from 1 to 6 gives `skip` when `prog_flag[n-1]` is 0.
- R5: A flag selector value of 7 gives `skip` only when all six bits of `prog_flag` are 0. A selector value of 0, in either field, never causes a skip.
- R6: With address bit 9 set (octal 1000), `skip` is 1 when the overflow flip-flop is 0. The test uses the flip-flop value from before any clear made by the same instruction.
- R7: When several selectors are active in one address, `skip` is the OR of their individual conditions, in the same cycle.
- R8: `skip` is combinational and follows the inputs in the same cycle. It is 0 whenever `exec_en` is 0.
- R9: `ovf_set` sets `ovf_flag` on the next clock edge, and `start_clr` clears it on the next edge. A clear wins over a set in the same cycle.
- R10: An executed instruction with address bit 9 set clears `ovf_flag` on the next clock edge.
- R11: While reset is asserted, and after it is released, `ovf_flag` is 0 until it is set.
- R12: Address bits 6, 7, 8 and 11 have no effect on `skip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | High in the cycle a skip instruction executes |
| addr | input | 12 | Address field of the instruction |
| io_sign | input | 1 | Sign bit of the in-out register |
| sense_sw | input | 6 | Sense switches; bit 0 is switch 1 |
| prog_flag | input | 6 | Program flags; bit 0 is flag 1 |
| start_clr | input | 1 | Start control; clears overflow |
| ovf_set | input | 1 | Overflow event from arithmetic |
| skip | output | 1 | Skip strobe |
| ovf_flag | output | 1 | Overflow flip-flop state |

## Verification
The bench drives both "all" codes with exactly one bit set, including the highest bit. A decoder that checks only part of the vector, or reads the value as a single index, would then skip when it should not. It drives selector value 0 with every switch and flag at 0, which catches a design that lets the "none" code reach an index. It executes an overflow test while the flip-flop is set and again while it is clear. This exposes a design that tests the value after its own clear, or that fails to clear at all. It also checks that a clear and a set in the same cycle leave the flip-flop cleared, and that the unused address bits and a low execute enable leave `skip` at 0.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int ADDR_W  = 12;
  localparam int SEL_W   = 3;
  localparam int N_SW    = 6;
  localparam int N_FLAG  = 6;
  localparam int FLAG_LO = 0;
  localparam int SW_LO   = 3;
  localparam int OVF_BIT = 9;
  localparam int IOS_BIT = 10;

  typedef struct packed {
    logic             io_test;
    logic             ovf_test;
    logic [SEL_W-1:0] sw_sel;
    logic [SEL_W-1:0] flag_sel;
  } skip_fields_t;
endpackage

// File: rtl/skip_rst_sync.sv
module skip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/skip_sel.sv
module skip_sel #(
  parameter int SEL_W = 3,
  parameter int N     = 6
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [N-1:0]     bits,
  output logic             hit
);
  localparam logic [SEL_W-1:0] ALL_CODE = {SEL_W{1'b1}};

  logic [N-1:0] one_hit;
  logic         all_hit;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_one
      assign one_hit[gi] = (sel == SEL_W'(gi + 1)) && !bits[gi];
    end
  endgenerate

  always_comb begin
    all_hit = (sel == ALL_CODE) && (bits == '0);
    hit     = all_hit || (|one_hit);
  end

  p_none_sel_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == '0) |-> !hit);
  p_all_code_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == ALL_CODE && hit) |-> (bits == '0));
endmodule

// File: rtl/skip_ovf.sv
module skip_ovf (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic set_i,
  input  logic start_clr_i,
  input  logic test_clr_i,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | start_clr_i | test_clr_i;
    q_d  = (start_clr_i | test_clr_i) ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  q <= 1'b0;
    else if (q_en)    q <= q_d;
  end

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_i && !start_clr_i && !test_clr_i) |=> q);
  p_start_clr_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_clr_i |=> !q);
  p_test_clr_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    test_clr_i |=> !q);
endmodule

// File: rtl/skip_decider.sv
module skip_decider
  import skip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_sign,
  input  logic [N_SW-1:0]   sense_sw,
  input  logic [N_FLAG-1:0] prog_flag,
  input  logic              start_clr,
  input  logic              ovf_set,
  output logic              skip,
  output logic              ovf_flag
);
  logic         rst_sync_n;
  skip_fields_t fld;
  logic         sw_hit;
  logic         flag_hit;
  logic         any_hit;

  always_comb begin
    fld.io_test  = addr[IOS_BIT];
    fld.ovf_test = addr[OVF_BIT];
    fld.sw_sel   = addr[SW_LO +: SEL_W];
    fld.flag_sel = addr[FLAG_LO +: SEL_W];
  end

  skip_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  skip_sel #(.SEL_W(SEL_W), .N(N_SW)) u_sw_sel (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .sel        (fld.sw_sel),
    .bits       (sense_sw),
    .hit        (sw_hit)
  );

  skip_sel #(.SEL_W(SEL_W), .N(N_FLAG)) u_flag_sel (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .sel        (fld.flag_sel),
    .bits       (prog_flag),
    .hit        (flag_hit)
  );

  skip_ovf u_ovf (
    .clk         (clk),
    .rst_sync_n  (rst_sync_n),
    .set_i       (ovf_set),
    .start_clr_i (start_clr),
    .test_clr_i  (exec_en & fld.ovf_test),
    .q           (ovf_flag)
  );

  always_comb begin
    any_hit = (fld.io_test && !io_sign)
            | (fld.ovf_test && !ovf_flag)
            | sw_hit
            | flag_hit;
    skip    = exec_en & any_hit;
  end

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_en |-> !skip);
  p_ovf_skip_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && fld.ovf_test && !ovf_flag) |-> skip);
  p_io_skip_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && fld.io_test && !io_sign) |-> skip);
  p_or_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && (sw_hit || flag_hit)) |-> skip);
endmodule

// File: tb/test_skip_decider.sv
module test_skip_decider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic [11:0] addr;
  logic        io_sign;
  logic [5:0]  sense_sw;
  logic [5:0]  prog_flag;
  logic        start_clr;
  logic        ovf_set;
  logic        skip;
  logic        ovf_flag;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  skip_decider i_skip_decider (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .addr(addr),
    .io_sign(io_sign), .sense_sw(sense_sw), .prog_flag(prog_flag),
    .start_clr(start_clr), .ovf_set(ovf_set), .skip(skip), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic sel_model(input logic [2:0] s, input logic [5:0] b);
    if (s == 3'd0) return 1'b0;
    if (s == 3'd7) return (b == 6'd0);
    return !b[s - 1];
  endfunction

  function automatic logic model(input logic [11:0] a, input logic ovf);
    return (a[10] && !io_sign) || (a[9] && !ovf) ||
           sel_model(a[5:3], sense_sw) || sel_model(a[2:0], prog_flag);
  endfunction

  task automatic apply(input logic [11:0] a, input string req);
    @(negedge clk);
    addr = a; exec_en = 1'b1;
    #1 check(req, skip, model(a, ovf_flag));
  endtask

  task automatic idle();
    @(negedge clk);
    exec_en = 1'b0; addr = '0; start_clr = 1'b0; ovf_set = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1 check("R11 reset", ovf_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R11 after release", ovf_flag, 1'b0);
    check("R8 idle", skip, 1'b0);
  endtask

  task automatic t_io();
    io_sign = 1'b0; sense_sw = 6'h3f; prog_flag = 6'h3f;
    apply(12'o2000, "R1 sign zero");
    io_sign = 1'b1;
    apply(12'o2000, "R1 sign one");
    idle();
  endtask

  task automatic t_switch();
    io_sign = 1'b1; prog_flag = 6'h3f;
    for (int n = 1; n <= 6; n++) begin
      sense_sw = ~(6'd1 << (n - 1));
      apply(12'(n * 8), "R2 selected zero");
      sense_sw = 6'd1 << (n - 1);
      apply(12'(n * 8), "R2 selected one");
    end
    sense_sw = 6'd0;
    apply(12'o70, "R3 all zero");
    sense_sw = 6'b100000;
    apply(12'o70, "R3 top bit set");
    sense_sw = 6'b000001;
    apply(12'o70, "R3 low bit set");
    sense_sw = 6'd0;
    apply(12'o00, "R5 switch none");
    idle();
  endtask

  task automatic t_flag();
    io_sign = 1'b1; sense_sw = 6'h3f;
    for (int n = 1; n <= 6; n++) begin
      prog_flag = ~(6'd1 << (n - 1));
      apply(12'(n), "R4 selected zero");
    end
    prog_flag = 6'd0;
    apply(12'o7, "R5 all zero");
    prog_flag = 6'b010000;
    apply(12'o7, "R5 one flag set");
    prog_flag = 6'd0;
    apply(12'o0, "R5 flag none");
    idle();
  endtask

  task automatic t_ovf();
    io_sign = 1'b1; sense_sw = 6'h3f; prog_flag = 6'h3f;
    @(negedge clk); ovf_set = 1'b1;
    @(negedge clk); ovf_set = 1'b0;
    #1 check("R9 set", ovf_flag, 1'b1);
    apply(12'o1000, "R6 flag set");
    idle();
    #1 check("R10 test clears", ovf_flag, 1'b0);
    apply(12'o1000, "R6 flag clear");
    idle();
    ovf_set = 1'b1;
    @(negedge clk); ovf_set = 1'b0; start_clr = 1'b1;
    @(negedge clk); start_clr = 1'b0;
    #1 check("R9 start clears", ovf_flag, 1'b0);
    ovf_set = 1'b1; start_clr = 1'b1;
    @(negedge clk); ovf_set = 1'b0; start_clr = 1'b0;
    #1 check("R9 clear wins", ovf_flag, 1'b0);
  endtask

  task automatic t_combine();
    sense_sw = 6'h3f; prog_flag = 6'h3f; io_sign = 1'b1;
    @(negedge clk); ovf_set = 1'b1;
    @(negedge clk); ovf_set = 1'b0;
    apply(12'o3000, "R7 neither");
    idle();
    @(negedge clk); ovf_set = 1'b1;
    @(negedge clk); ovf_set = 1'b0;
    io_sign = 1'b0;
    apply(12'o3000, "R7 sign only");
    idle();
    io_sign = 1'b1; prog_flag = 6'b111011;
    apply(12'o2023, "R7 flag only");
    idle();
  endtask

  task automatic t_gate_ignore();
    io_sign = 1'b0; sense_sw = 6'd0; prog_flag = 6'd0;
    @(negedge clk); exec_en = 1'b0; addr = 12'o2077;
    #1 check("R8 enable low", skip, 1'b0);
    io_sign = 1'b1; sense_sw = 6'h3f; prog_flag = 6'h3f;
    @(negedge clk); ovf_set = 1'b1;
    @(negedge clk); ovf_set = 1'b0;
    apply(12'o4700, "R12 unused bits");
    idle();
    #1 check("R12 ovf untouched", ovf_flag, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; addr = '0; io_sign = 1'b1;
    sense_sw = '0; prog_flag = '0; start_clr = 1'b0; ovf_set = 1'b0;
    t_reset();
    t_io();
    t_switch();
    t_flag();
    t_ovf();
    t_combine();
    t_gate_ignore();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule